// File: doc/BRIEF.md
# Byte-lane asynchronous SRAM core

This block is a synthesizable stand-in for a 16-bit-wide static RAM whose control pins behave like level-sensitive asynchronous inputs. A fast sampling clock observes the pins. The pins are an address, an active-low chip select, an active-high chip select, an active-low output enable, an active-low write enable, and one active-low enable for each byte lane. The bidirectional data bus is split into a data-in bus, a data-out bus and one registered output-enable per byte lane. A pad ring or a surrounding testbench can merge these into a tri-state bus.

Each sampled cycle decodes the pins into one of five modes: standby, no lane enabled, output disabled, read, or write. A write is the overlap window of both chip selects being active, the write enable being low and at least one byte enable being low. While that window is open, the block tracks the address, the data and the lane mask. It commits them to the array in the cycle the window closes. The full-size device uses `ADDR_W = 17`, which gives 131072 words. The default is kept small so that the design elaborates quickly.

Top module: `sram_bytelane_core`

## Requirements
- R1: When `cs_lo_n` is 1 or `cs_hi` is 0 in a sampled cycle, `lane_oe` is `2'b00` one cycle later, and no array word changes, whatever the other pins do.
- R2: When both `upper_n` and `lower_n` are 1, `lane_oe` is `2'b00` one cycle later and no write takes place, even while selected.
- R3: When selected with `we_n` = 1 and `oe_n` = 1, `lane_oe` is `2'b00` one cycle later.
- R4: When selected with `we_n` = 1 and `oe_n` = 0, one cycle later `lane_oe[0]` = !`lower_n` and `lane_oe[1]` = !`upper_n`. Each enabled lane presents the stored byte on `dout` (bits 7:0 for the lower lane, bits 15:8 for the upper lane), and `dout` bits of a disabled lane are 0.
- R5: When selected with `we_n` = 0, `oe_n` is ignored and `lane_oe` is `2'b00` one cycle later.
- R6: A write updates only the lanes whose byte enable is 0 during the window. The other byte of the word keeps its previous contents.
- R7: The stored word, lane mask and address are those sampled in the last cycle of the write window, even if data or address changed while the window was open.
- R8: The write window closes when any one of three things happens: `cs_lo_n` rises, `cs_hi` falls, or `we_n` rises. Each of the three closes it and commits the write.
- R9: A read sampled in the same cycle that a window closes, to the same address, returns the newly committed data.
- R10: While `rst_n` is 0, `lane_oe` and `dout` are 0, and no write is pending after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| cs_lo_n | input | 1 | Chip select, active low |
| cs_hi | input | 1 | Chip select, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| upper_n | input | 1 | Upper byte enable (bits 15:8), active low |
| lower_n | input | 1 | Lower byte enable (bits 7:0), active low |
| din | input | DATA_W | Write data from the bus |
| dout | output | DATA_W | Read data toward the bus, zero on lanes not driven |
| lane_oe | output | 2 | Per-lane drive enable: bit 0 lower lane, bit 1 upper lane |

## Verification
Reads and writes are tried with full-word, lower-only and upper-only byte masks, at the lowest and highest addresses, and with all-ones and all-zeros patterns. These runs separate a lane-swap or a mask fault from a plain data-path fault. Each of the three ways of closing a write window is tried on its own, along with windows in which the data and the address change before closing. These runs show whether the commit uses the final sample and whether each close event is recognised. The quiet modes are driven with the output enable low wherever possible, and so are attempted writes while deselected or with both lanes off. This exposes any decode that lets a lane drive or store when it should not. A read at the closing edge of a write tells a forwarding path apart from a stale array read.

// File: rtl/sram_bl_pkg.sv
package sram_bl_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY = 3'd0,
    MODE_NOLANE  = 3'd1,
    MODE_OUTOFF  = 3'd2,
    MODE_READ    = 3'd3,
    MODE_WRITE   = 3'd4
  } sram_mode_e;

  localparam int unsigned LANES = 2;

endpackage

// File: rtl/sram_bl_decode.sv
module sram_bl_decode
  import sram_bl_pkg::*;
#(
  parameter int unsigned NLANE = LANES
) (
  input  logic             cs_lo_n,
  input  logic             cs_hi,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic [NLANE-1:0] be_n,
  output sram_mode_e       mode,
  output logic [NLANE-1:0] lane_on
);

  logic selected;
  logic any_lane;

  always_comb begin
    selected = !cs_lo_n && cs_hi;
    lane_on  = ~be_n;
    any_lane = |lane_on;
    if (!selected) begin
      mode = MODE_STANDBY;
    end else if (!any_lane) begin
      mode = MODE_NOLANE;
    end else if (!we_n) begin
      mode = MODE_WRITE;
    end else if (!oe_n) begin
      mode = MODE_READ;
    end else begin
      mode = MODE_OUTOFF;
    end
  end

endmodule

// File: rtl/sram_bl_wcap.sv
module sram_bl_wcap #(
  parameter int unsigned AW    = 10,
  parameter int unsigned DW    = 16,
  parameter int unsigned NLANE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cond,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  input  logic [NLANE-1:0] lane_on,
  output logic             commit,
  output logic [AW-1:0]    c_addr,
  output logic [DW-1:0]    c_data,
  output logic [NLANE-1:0] c_mask
);

  logic             open_q, open_d;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    data_q;
  logic [NLANE-1:0] mask_q;
  logic             cap_en;

  always_comb begin
    open_d = wr_cond;
    cap_en = wr_cond;
    commit = open_q && !wr_cond;
    c_addr = addr_q;
    c_data = data_q;
    c_mask = mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
    end else begin
      open_q <= open_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q <= addr;
      data_q <= din;
      mask_q <= lane_on;
    end
  end

endmodule

// File: rtl/sram_bl_array.sv
module sram_bl_array #(
  parameter int unsigned AW     = 10,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned NLANE  = 2
) (
  input  logic                    clk,
  input  logic [NLANE-1:0]        wr_en,
  input  logic [AW-1:0]           waddr,
  input  logic [NLANE*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [NLANE*LANE_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en[g]) begin
        mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end

endmodule

// File: rtl/sram_bytelane_core.sv
module sram_bytelane_core
  import sram_bl_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs_lo_n,
  input  logic              cs_hi,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              upper_n,
  input  logic              lower_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [1:0]        lane_oe
);

  localparam int unsigned NL     = LANES;
  localparam int unsigned LANE_W = DATA_W / NL;

  sram_mode_e        mode;
  logic [NL-1:0]     be_n;
  logic [NL-1:0]     lane_on;
  logic              wr_cond;
  logic              commit;
  logic [ADDR_W-1:0] c_addr;
  logic [DATA_W-1:0] c_data;
  logic [NL-1:0]     c_mask;
  logic [NL-1:0]     arr_we;
  logic [DATA_W-1:0] rdata;
  logic [DATA_W-1:0] fwd_data;
  logic              hit;
  logic [NL-1:0]     oe_d, oe_q;
  logic [DATA_W-1:0] dout_d, dout_q;

  assign be_n = {upper_n, lower_n};

  sram_bl_decode #(.NLANE(NL)) i_decode (
    .cs_lo_n (cs_lo_n),
    .cs_hi   (cs_hi),
    .oe_n    (oe_n),
    .we_n    (we_n),
    .be_n    (be_n),
    .mode    (mode),
    .lane_on (lane_on)
  );

  assign wr_cond = (mode == MODE_WRITE);

  sram_bl_wcap #(.AW(ADDR_W), .DW(DATA_W), .NLANE(NL)) i_wcap (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_cond (wr_cond),
    .addr    (addr),
    .din     (din),
    .lane_on (lane_on),
    .commit  (commit),
    .c_addr  (c_addr),
    .c_data  (c_data),
    .c_mask  (c_mask)
  );

  assign arr_we = c_mask & {NL{commit}};

  sram_bl_array #(.AW(ADDR_W), .LANE_W(LANE_W), .NLANE(NL)) i_array (
    .clk   (clk),
    .wr_en (arr_we),
    .waddr (c_addr),
    .wdata (c_data),
    .raddr (addr),
    .rdata (rdata)
  );

  assign hit = commit && (c_addr == addr);

  for (genvar g = 0; g < NL; g++) begin : g_out
    always_comb begin
      if (hit && c_mask[g]) begin
        fwd_data[g*LANE_W +: LANE_W] = c_data[g*LANE_W +: LANE_W];
      end else begin
        fwd_data[g*LANE_W +: LANE_W] = rdata[g*LANE_W +: LANE_W];
      end
      oe_d[g] = (mode == MODE_READ) && lane_on[g];
      if (oe_d[g]) begin
        dout_d[g*LANE_W +: LANE_W] = fwd_data[g*LANE_W +: LANE_W];
      end else begin
        dout_d[g*LANE_W +: LANE_W] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= '0;
      dout_q <= '0;
    end else begin
      oe_q   <= oe_d;
      dout_q <= dout_d;
    end
  end

  assign lane_oe = oe_q;
  assign dout    = dout_q;

endmodule

// File: rtl/sram_bytelane_chk.sv
module sram_bytelane_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_lo_n,
  input logic              cs_hi,
  input logic              oe_n,
  input logic              we_n,
  input logic              upper_n,
  input logic              lower_n,
  input logic [DATA_W-1:0] dout,
  input logic [1:0]        lane_oe
);

  localparam int unsigned HALF = DATA_W / 2;

  // R1
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_lo_n || !cs_hi) |=> (lane_oe == 2'b00));

  // R2
  nolane_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upper_n && lower_n) |=> (lane_oe == 2'b00));

  // R3
  outoff_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_lo_n && cs_hi && we_n && oe_n) |=> (lane_oe == 2'b00));

  // R5
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n) |=> (lane_oe == 2'b00));

  // R4
  read_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_lo_n && cs_hi && we_n && !oe_n) |=> (lane_oe == ~$past({upper_n, lower_n})));

  // R4
  idle_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lane_oe[0]) |-> (dout[HALF-1:0] == '0));

  // R4
  idle_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lane_oe[1]) |-> (dout[DATA_W-1:HALF] == '0));

endmodule

bind sram_bytelane_core sram_bytelane_chk #(.DATA_W(DATA_W)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_lo_n (cs_lo_n),
  .cs_hi   (cs_hi),
  .oe_n    (oe_n),
  .we_n    (we_n),
  .upper_n (upper_n),
  .lower_n (lower_n),
  .dout    (dout),
  .lane_oe (lane_oe)
);

// File: tb/test_sram_bytelane_core.sv
`timescale 1ns/1ps
module test_sram_bytelane_core;

  localparam int unsigned AW = 10;
  localparam int unsigned DW = 16;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          cs_lo_n, cs_hi, oe_n, we_n, upper_n, lower_n;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic [1:0]    lane_oe;

  int checks;
  int errors;
  bit done;

  logic [DW-1:0] ref_mem [1 << AW];

  sram_bytelane_core #(.ADDR_W(AW), .DATA_W(DW)) i_sram_bytelane_core (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs_lo_n(cs_lo_n), .cs_hi(cs_hi),
    .oe_n(oe_n), .we_n(we_n), .upper_n(upper_n), .lower_n(lower_n),
    .din(din), .dout(dout), .lane_oe(lane_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic c1n, input logic c2, input logic oen, input logic wen,
                      input logic un, input logic ln, input logic [AW-1:0] a,
                      input logic [DW-1:0] d);
    cs_lo_n = c1n; cs_hi = c2; oe_n = oen; we_n = wen;
    upper_n = un; lower_n = ln; addr = a; din = d;
    @(negedge clk);
  endtask

  task automatic idle();
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
  endtask

  task automatic ref_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic un, input logic ln);
    if (!ln) ref_mem[a][7:0]  = d[7:0];
    if (!un) ref_mem[a][15:8] = d[15:8];
  endtask

  // one-cycle window; OE held low to show it is ignored (R5)
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic un, input logic ln);
    step(1'b0, 1'b1, 1'b0, 1'b0, un, ln, a, d);
    chk("R5 lane_oe during write", {14'd0, lane_oe}, 16'd0);
    idle();
    ref_write(a, d, un, ln);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic un, input logic ln, input string req);
    logic [DW-1:0] exp;
    step(1'b0, 1'b1, 1'b0, 1'b1, un, ln, a, 16'hDEAD);
    exp = ref_mem[a];
    if (ln) exp[7:0]  = 8'h00;
    if (un) exp[15:8] = 8'h00;
    chk({req, " lane_oe"}, {14'd0, lane_oe}, {14'd0, !un, !ln});
    chk({req, " dout"}, dout, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0);
    chk("R10 lane_oe in reset", {14'd0, lane_oe}, 16'd0);
    chk("R10 dout in reset", dout, 16'd0);
    rst_n = 1'b1;
    idle();
    chk("R10 lane_oe after reset", {14'd0, lane_oe}, 16'd0);
  endtask

  task automatic t_word_rw();
    wr(10'd0,    16'hA5C3, 1'b0, 1'b0);
    wr(10'd1023, 16'hFFFF, 1'b0, 1'b0);
    wr(10'd77,   16'h0000, 1'b0, 1'b0);
    wr(10'd300,  16'h1234, 1'b0, 1'b0);
    rd(10'd0,    1'b0, 1'b0, "R4 word addr 0");
    rd(10'd1023, 1'b0, 1'b0, "R4 word addr max");
    rd(10'd77,   1'b0, 1'b0, "R4 word zeros");
    rd(10'd300,  1'b1, 1'b0, "R4 lower lane only");
    rd(10'd300,  1'b0, 1'b1, "R4 upper lane only");
  endtask

  task automatic t_byte_lanes();
    wr(10'd5, 16'h1122, 1'b0, 1'b0);
    wr(10'd5, 16'hEEAB, 1'b1, 1'b0);
    rd(10'd5, 1'b0, 1'b0, "R6 lower-only write");
    wr(10'd5, 16'h9CFF, 1'b0, 1'b1);
    rd(10'd5, 1'b0, 1'b0, "R6 upper-only write");
  endtask

  task automatic t_quiet_modes();
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 10'd0, '0);
    chk("R1 cs_lo_n high", {14'd0, lane_oe}, 16'd0);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'd0, '0);
    chk("R1 cs_hi low", {14'd0, lane_oe}, 16'd0);
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 10'd0, '0);
    chk("R2 both lanes off", {14'd0, lane_oe}, 16'd0);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'd0, '0);
    chk("R3 output disabled", {14'd0, lane_oe}, 16'd0);
    chk("R3 dout zero", dout, 16'd0);
    idle();
  endtask

  task automatic t_no_store();
    wr(10'd9, 16'h5A5A, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'd9, 16'h0F0F);
    idle();
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'd9, 16'h0F0F);
    idle();
    rd(10'd9, 1'b0, 1'b0, "R1 deselected write ignored");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 10'd9, 16'h3333);
    idle();
    rd(10'd9, 1'b0, 1'b0, "R2 no-lane write ignored");
  endtask

  task automatic t_last_sample();
    wr(10'd20, 16'h2020, 1'b0, 1'b0);
    wr(10'd21, 16'h2121, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'd20, 16'hAAAA);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'd20, 16'hBBBB);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 10'd21, 16'hC3C4);
    idle();
    ref_write(10'd21, 16'hC3C4, 1'b1, 1'b0);
    rd(10'd20, 1'b0, 1'b0, "R7 earlier address untouched");
    rd(10'd21, 1'b0, 1'b0, "R7 last data, address and mask");
  endtask

  task automatic t_close_variants();
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'd40, 16'h4141);
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'd40, 16'h4141);
    ref_write(10'd40, 16'h4141, 1'b0, 1'b0);
    idle();
    rd(10'd40, 1'b0, 1'b0, "R8 closed by cs_lo_n");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'd41, 16'h4242);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'd41, 16'h4242);
    ref_write(10'd41, 16'h4242, 1'b0, 1'b0);
    idle();
    rd(10'd41, 1'b0, 1'b0, "R8 closed by cs_hi");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'd42, 16'h4343);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'd42, 16'h4343);
    ref_write(10'd42, 16'h4343, 1'b0, 1'b0);
    idle();
    rd(10'd42, 1'b0, 1'b0, "R8 closed by we_n");
  endtask

  task automatic t_bypass();
    wr(10'd60, 16'h6000, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 10'd60, 16'hFF6E);
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 10'd60, 16'h0000);
    chk("R9 read at closing edge", dout, 16'h606E);
    ref_write(10'd60, 16'hFF6E, 1'b1, 1'b0);
    idle();
    rd(10'd60, 1'b0, 1'b0, "R9 value after close");
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0;
    cs_lo_n = 1'b1; cs_hi = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    upper_n = 1'b1; lower_n = 1'b1; addr = '0; din = '0;
    @(negedge clk);
    t_reset();
    t_word_rw();
    t_byte_lanes();
    t_quiet_modes();
    t_no_store();
    t_last_sample();
    t_close_variants();
    t_bypass();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule